// File: doc/BRIEF.md
# Interrupt status and mask controller

This block gathers up to 32 peripheral interrupt lines into one status word, qualifies them with a software-owned enable mask, and drives a single level-sensitive interrupt request towards a host processor. Lines are of two kinds. Below a fixed boundary index, each status bit is simply the live level of its source, so it cannot be cleared from software. From the boundary upward, each line is a DMA event that is caught in a sticky bit and held until software clears it.

DMA lines are further divided by a fixed per-line parameter into informational events and error events. An informational event only raises its status bit, and it will raise it again whenever the source fires after a clear. An error event also holds a halt signal on its own DMA channel for as long as its status bit stays set. A status bit is cleared by writing a zero to its position, so writing the complement of a one-hot word clears exactly one event.

Software reaches both words through a small synchronous register port. Reads are registered, and the mask is normally updated by read-modify-write.

Top module: `irq_status_ctrl`

## Requirements
- R1: A write to offset 0x04 loads the mask register. A read of 0x04 returns exactly the last value written, one clock after the read strobe.
- R2: While reset is active, and after it is released, the mask and all DMA status bits are 0, every halt output is low and the interrupt output is low.
- R3: Status bits with index below DMA_BASE (default 16) read back as the live source level at the read edge. Writes to offset 0x00 have no effect on them.
- R4: A DMA status bit (index DMA_BASE and above) is set at the first clock edge where its source is high, and it stays set after the source falls.
- R5: Writing offset 0x00 clears each DMA status bit whose write-data bit is 0 and leaves each bit written with 1 unchanged.
- R6: If a DMA source is high at the same edge as a clear of its bit, the bit stays set.
- R7: An informational DMA line (its bit is 1 in INFO_MASK, default 0x0F0F_0000) sets again when its source fires after a clear, and it never raises a halt.
- R8: halt_o[k] follows status bit DMA_BASE+k for every error DMA line (its INFO_MASK bit is 0). The halt is held until that bit is cleared.
- R9: irq_o is high exactly when some bit of the status word AND the mask word is 1, and it changes without a clock edge when a level line changes.
- R10: A read of any offset other than 0x00 and 0x04 returns 0.
- R11: With the mask all zeros, irq_o stays low whatever the status word holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| src_i | input | NUM_LINES | Interrupt source levels, synchronous to clk |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | NUM_LINES | Write data |
| reg_rdata_o | output | NUM_LINES | Read data, registered, valid the cycle after reg_rd_i |
| irq_o | output | 1 | Level interrupt request to the processor |
| halt_o | output | NUM_LINES-DMA_BASE | Per-channel DMA halt, one per DMA line; tied low on informational lines |

## Verification
The functions that collide are the capture of a new DMA event and the clear of that event by a software write to the status word. Both act on the same sticky bit at the same edge. The bench provokes the collision on purpose by holding a DMA source high during a zero-write to its bit. Random traffic also produces the collision, by mixing source pulses with one-hot-complement status writes. The outcome is judged by reading the status word back and by watching the halt output. A reference model in the bench applies the clear first and then ORs in the set.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  localparam logic [7:0] OFF_STATUS = 8'h00;
  localparam logic [7:0] OFF_MASK   = 8'h04;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_MASK   = 2'd2
  } rd_sel_e;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] mask_o
);

  logic [WIDTH-1:0] mask_q;
  logic [WIDTH-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (wr_en_i) mask_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_en_i) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  // R1
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (mask_o == $past(wdata_i)));

  // R1
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(mask_o));

endmodule

// File: rtl/irq_dma_event_bank.sv
module irq_dma_event_bank #(
  parameter int                   NUM_LINES = 32,
  parameter int                   DMA_BASE  = 16,
  parameter logic [NUM_LINES-1:0] INFO_MASK = '0,
  localparam int                  NUM_DMA   = NUM_LINES - DMA_BASE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DMA-1:0] src_i,
  input  logic               clr_wr_i,
  input  logic [NUM_DMA-1:0] wdata_i,
  output logic [NUM_DMA-1:0] status_o,
  output logic [NUM_DMA-1:0] halt_o
);

  for (genvar j = 0; j < NUM_DMA; j++) begin : g_line
    logic evt_q;
    logic evt_d;
    logic clr;

    assign clr = clr_wr_i & ~wdata_i[j];

    always_comb begin
      evt_d = evt_q;
      if (clr)      evt_d = 1'b0;
      if (src_i[j]) evt_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q <= 1'b0;
      else        evt_q <= evt_d;
    end

    assign status_o[j] = evt_q;

    if (INFO_MASK[DMA_BASE+j]) begin : g_info
      assign halt_o[j] = 1'b0;
    end else begin : g_err
      assign halt_o[j] = evt_q;
    end

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_i[j] |=> status_o[j]);

    // R5
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr_i && !wdata_i[j] && !src_i[j]) |=> !status_o[j]);

    // R4
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[j] && !(clr_wr_i && !wdata_i[j])) |=> status_o[j]);
  end

endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import irq_ctrl_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  status_i,
  input  logic [WIDTH-1:0]  mask_i,
  output logic [WIDTH-1:0]  rdata_o
);

  rd_sel_e          sel;
  logic [WIDTH-1:0] rdata_q;
  logic [WIDTH-1:0] rdata_d;

  always_comb begin
    sel = SEL_NONE;
    if (addr_i == ADDR_W'(OFF_STATUS)) sel = SEL_STATUS;
    else if (addr_i == ADDR_W'(OFF_MASK)) sel = SEL_MASK;
  end

  always_comb begin
    unique case (sel)
      SEL_STATUS: rdata_d = status_i;
      SEL_MASK:   rdata_d = mask_i;
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_q <= '0;
    else if (rd_i) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && addr_i != ADDR_W'(OFF_STATUS) && addr_i != ADDR_W'(OFF_MASK))
      |=> (rdata_o == '0));

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int                   NUM_LINES = 32,
  parameter int                   DMA_BASE  = 16,
  parameter logic [NUM_LINES-1:0] INFO_MASK = 32'h0F0F_0000,
  parameter int                   ADDR_W    = 8,
  localparam int                  NUM_DMA   = NUM_LINES - DMA_BASE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] src_i,
  input  logic                 reg_wr_i,
  input  logic                 reg_rd_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [NUM_LINES-1:0] reg_wdata_i,
  output logic [NUM_LINES-1:0] reg_rdata_o,
  output logic                 irq_o,
  output logic [NUM_DMA-1:0]   halt_o
);

  logic                 rst_n_int;
  logic                 stat_wr;
  logic                 mask_wr;
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_DMA-1:0]   dma_status;
  logic [NUM_LINES-1:0] status_word;

  irq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_int)
  );

  assign stat_wr = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_STATUS));
  assign mask_wr = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_MASK));

  irq_mask_reg #(.WIDTH(NUM_LINES)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en_i (mask_wr),
    .wdata_i (reg_wdata_i),
    .mask_o  (mask_q)
  );

  irq_dma_event_bank #(
    .NUM_LINES (NUM_LINES),
    .DMA_BASE  (DMA_BASE),
    .INFO_MASK (INFO_MASK)
  ) u_dma (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .src_i    (src_i[NUM_LINES-1:DMA_BASE]),
    .clr_wr_i (stat_wr),
    .wdata_i  (reg_wdata_i[NUM_LINES-1:DMA_BASE]),
    .status_o (dma_status),
    .halt_o   (halt_o)
  );

  assign status_word = {dma_status, src_i[DMA_BASE-1:0]};
  assign irq_o       = |(status_word & mask_q);

  irq_read_port #(.WIDTH(NUM_LINES), .ADDR_W(ADDR_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .rd_i     (reg_rd_i),
    .addr_i   (reg_addr_i),
    .status_i (status_word),
    .mask_i   (mask_q),
    .rdata_o  (reg_rdata_o)
  );

  // R11
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (mask_q == '0) |-> !irq_o);

  // R2
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n_int |-> (!irq_o && halt_o == '0));

  // R8
  halt_release_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    ((halt_o & ~$past(halt_o)) != '0) |-> ($past(src_i[NUM_LINES-1:DMA_BASE]) != '0));

endmodule

// File: tb/irq_status_ctrl_tb.sv
`timescale 1ns/1ps
module irq_status_ctrl_tb;

  localparam logic [31:0] INFO = 32'h0F0F_0000;
  localparam int          WATCHDOG_CYC = 200000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src;
  logic        wr, rd;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  logic [15:0] halt;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_dma;
  logic [31:0] m_mask;
  logic [31:0] last_rd;

  always #2 clk = ~clk;

  irq_status_ctrl u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src),
    .reg_wr_i    (wr),
    .reg_rd_i    (rd),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq),
    .halt_o      (halt)
  );

  function automatic logic f_irq(logic [15:0] dma, logic [15:0] lvl, logic [31:0] msk);
    return |({dma, lvl} & msk);
  endfunction

  function automatic logic [15:0] f_halt(logic [15:0] dma);
    return dma & ~INFO[31:16];
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] s, input logic we, input logic re,
                      input logic [7:0] a, input logic [31:0] d, input string tag);
    logic [31:0] exp_rd;
    src = s; wr = we; rd = re; addr = a; wdata = d;
    exp_rd = (a == 8'h00) ? {m_dma, s[15:0]} : (a == 8'h04) ? m_mask : 32'h0;
    @(posedge clk); #1;
    if (we && a == 8'h00) m_dma = m_dma & d[31:16];
    m_dma = m_dma | s[31:16];
    if (we && a == 8'h04) m_mask = d;
    chk(irq == f_irq(m_dma, s[15:0], m_mask), "R9 irq", {31'd0, irq}, {31'd0, f_irq(m_dma, s[15:0], m_mask)});
    chk(halt == f_halt(m_dma), "R8 halt", {16'd0, halt}, {16'd0, f_halt(m_dma)});
    if (re) begin
      last_rd = rdata;
      chk(rdata == exp_rd, tag, rdata, exp_rd);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; src = '0; wr = 0; rd = 0; addr = '0; wdata = '0;
    m_dma = '0; m_mask = '0; last_rd = '0;
    repeat (3) @(negedge clk);
    // R2: outputs quiet under reset even with sources active
    src = 32'hFFFF_FFFF;
    #1;
    chk(!irq && halt == 16'h0, "R2 reset outputs", {15'd0, irq, halt}, 32'h0);
    src = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: mask and status read zero after reset
    step('0, 0, 1, 8'h04, '0, "R2 mask after reset");
    chk(last_rd == 32'h0, "R2 mask zero", last_rd, 32'h0);
    step('0, 0, 1, 8'h00, '0, "R2 status after reset");
    chk(last_rd == 32'h0, "R2 status zero", last_rd, 32'h0);

    // R1: mask read-back
    step('0, 1, 0, 8'h04, 32'hA5A5_5A5A, "R1 write");
    step('0, 0, 1, 8'h04, '0, "R1 readback");
    chk(last_rd == 32'hA5A5_5A5A, "R1 mask value", last_rd, 32'hA5A5_5A5A);

    // R3: level bit cannot be cleared
    step(32'h0000_0008, 1, 0, 8'h00, 32'h0, "R3 write zero");
    step(32'h0000_0008, 0, 1, 8'h00, '0, "R3 read");
    chk(last_rd[3] == 1'b1, "R3 level live", {31'd0, last_rd[3]}, 32'd1);
    step('0, 0, 1, 8'h00, '0, "R3 read low");
    chk(last_rd[3] == 1'b0, "R3 level follows", {31'd0, last_rd[3]}, 32'd0);

    // R4/R8: error line 20 pulse, line 21 pulse
    step(32'h0030_0000, 0, 0, 8'h00, '0, "R4 pulse");
    step('0, 0, 1, 8'h00, '0, "R4 read");
    chk(last_rd[21:20] == 2'b11, "R4 sticky", {30'd0, last_rd[21:20]}, 32'd3);
    chk(halt[4] == 1'b1, "R8 halt set", {31'd0, halt[4]}, 32'd1);

    // R5: clear only bit 20
    step('0, 1, 0, 8'h00, ~(32'h1 << 20), "R5 clear");
    step('0, 0, 1, 8'h00, '0, "R5 read");
    chk(last_rd[21:20] == 2'b10, "R5 single clear", {30'd0, last_rd[21:20]}, 32'd2);
    chk(halt[5:4] == 2'b10, "R8 halt held", {30'd0, halt[5:4]}, 32'd2);

    // R6: set and clear together on bit 21
    step(32'h0020_0000, 1, 0, 8'h00, 32'h0, "R6 collide");
    step('0, 0, 1, 8'h00, '0, "R6 read");
    chk(last_rd[21] == 1'b1, "R6 set wins", {31'd0, last_rd[21]}, 32'd1);
    step('0, 1, 0, 8'h00, 32'h0, "R5 clear all");

    // R7: informational line 16 retrigger
    step(32'h0001_0000, 0, 0, 8'h00, '0, "R7 pulse1");
    chk(halt[0] == 1'b0, "R7 no halt", {31'd0, halt[0]}, 32'd0);
    step('0, 1, 0, 8'h00, ~(32'h1 << 16), "R7 clear");
    step(32'h0001_0000, 0, 0, 8'h00, '0, "R7 pulse2");
    step('0, 0, 1, 8'h00, '0, "R7 read");
    chk(last_rd[16] == 1'b1, "R7 re-set", {31'd0, last_rd[16]}, 32'd1);

    // R10: unmapped offsets
    step('0, 0, 1, 8'h08, '0, "R10 read 0x08");
    chk(last_rd == 32'h0, "R10 zero", last_rd, 32'h0);
    step('0, 0, 1, 8'hFC, '0, "R10 read 0xFC");

    // R11: all-zero mask silences irq
    step('0, 1, 0, 8'h04, 32'h0, "R11 mask zero");
    step(32'h0000_FFFF, 0, 0, 8'h00, '0, "R11 level");
    chk(irq == 1'b0, "R11 masked", {31'd0, irq}, 32'd0);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] s, d;
      logic [7:0]  a;
      logic        we, re;
      int          k;
      s  = $urandom & $urandom & $urandom;
      we = ($urandom % 4) == 0;
      re = ($urandom % 3) == 0;
      case ($urandom % 5)
        0, 1:    a = 8'h00;
        2, 3:    a = 8'h04;
        default: a = 8'(($urandom % 64) * 4);
      endcase
      k = 16 + int'($urandom % 16);
      d = (a == 8'h00 && ($urandom % 2) == 0) ? ~(32'h1 << k) : $urandom;
      step(s, we, re, a, d, "R1 R3 R5 R10 random read");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule